// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This unit runs beside a processor pipeline and carries out integer multiplication and division on its own, over many clock cycles. A start pulse carries an operation code and two 32-bit operands. The unit then works one bit per cycle. When it finishes, it writes the 64-bit outcome into two dedicated result registers, HI and LO. The pipeline keeps running while the unit works.

HI and LO are not general-purpose registers. The pipeline reads them through two read requests: one for the high register and one for the low register. While an operation is in flight, any read request raises a stall output, so the pipeline waits until the result is valid. Both registers can also be loaded directly from the pipeline while the unit is idle. A start pulse that arrives during an operation abandons the old operation and begins the new one. The unit has no overflow or error flag; software checks for overflow itself.

Top module: `muldiv_unit`

## Requirements
- R1: With op = 2'b01 (unsigned multiply), HI receives bits 63..32 and LO receives bits 31..0 of the unsigned 64-bit product of src_a and src_b.
- R2: With op = 2'b00 (signed multiply), HI:LO receives the two's-complement 64-bit product of src_a and src_b, both read as signed.
- R3: With op = 2'b11 (unsigned divide), LO receives the unsigned quotient src_a / src_b and HI receives the remainder.
- R4: With op = 2'b10 (signed divide), the quotient in LO is truncated toward zero, and the remainder in HI takes the sign of the dividend src_a.
- R5: busy rises on the clock edge that samples start and stays high for exactly 32 cycles. HI and LO are written on the edge where busy falls, and they hold their values for as long as busy is high.
- R6: hi_data and lo_data always show HI and LO. read_stall is high exactly when rd_hi or rd_lo is asserted while busy is high.
- R7: When the divisor is zero, a divide still completes in 32 cycles. LO becomes all ones and HI becomes the dividend src_a.
- R8: A start pulse while busy is high abandons the current operation. The new operation completes 32 cycles after that pulse and leaves only its own result.
- R9: When busy is low, wr_hi loads wr_data into HI and wr_lo loads wr_data into LO on the next edge. While busy is high, both write strobes are ignored.
- R10: No overflow is flagged. The signed divide 0x80000000 / 0xFFFFFFFF yields LO = 0x80000000 and HI = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears HI, LO and busy |
| start | input | 1 | Begin an operation, sampled on the rising edge |
| op | input | 2 | Operation: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| wr_hi | input | 1 | Direct write strobe for HI |
| wr_lo | input | 1 | Direct write strobe for LO |
| wr_data | input | 32 | Data for direct writes |
| rd_hi | input | 1 | Read request for HI |
| rd_lo | input | 1 | Read request for LO |
| hi_data | output | 32 | Current HI value |
| lo_data | output | 32 | Current LO value |
| busy | output | 1 | An operation is in flight |
| read_stall | output | 1 | A read request must wait |

## Verification
The bench targets several corner cases:
- **Most negative operand in signed multiply.** A unit that negates operands without sign extension returns a wrong upper half.
- **All four sign combinations of signed divide.** If the sign fix-up is wrong, a remainder with the divisor's sign, or a quotient rounded toward minus infinity, shows up.
- **Division by zero.** It has to finish on time and return the dividend in HI and all ones in LO. A raw engine result would leave a negated quotient or a magnitude in place of the dividend.
- **Abort and blocked writes.** A restart issued mid-operation and a direct write issued while busy both check that stale results or writes never reach HI or LO.
- **Read interlock.** Reads are checked both during an operation and after it, to catch a stall that is missing or one that sticks.

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] wr_data,
  input  logic         rd_hi,
  input  logic         rd_lo,
  output logic [W-1:0] hi_data,
  output logic [W-1:0] lo_data,
  output logic         busy,
  output logic         read_stall
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]   hi_q, lo_q, mplier, mplier_n;
  logic [2*W-1:0] acc, acc_n, mcand, mcand_n;
  logic [CW-1:0]  cnt;
  logic           is_div, neg_q, neg_r, dz;

  wire           sgn   = ~op[0];
  wire           a_neg = sgn & src_a[W-1];
  wire           b_neg = sgn & src_b[W-1];
  wire [2*W-1:0] a_ext = {{W{a_neg}}, src_a};
  wire [W-1:0]   a_mag = a_neg ? -src_a : src_a;
  wire [W-1:0]   b_mag = b_neg ? -src_b : src_b;

  wire [W:0] trial = {acc[W-1:0], mplier[W-1]} - {1'b0, mcand[W-1:0]};
  wire       ge    = ~trial[W];

  always_comb begin
    if (is_div) begin
      acc_n    = {{W{1'b0}}, ge ? trial[W-1:0] : {acc[W-2:0], mplier[W-1]}};
      mplier_n = {mplier[W-2:0], ge};
      mcand_n  = mcand;
    end else begin
      acc_n    = acc + (mplier[0] ? mcand : '0);
      mplier_n = mplier >> 1;
      mcand_n  = mcand << 1;
    end
  end

  wire [W-1:0] quo = dz ? '1 : (neg_q ? -mplier_n : mplier_n);
  wire [W-1:0] rem = neg_r ? -acc_n[W-1:0] : acc_n[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0; lo_q <= '0; busy <= 1'b0; cnt <= '0;
      acc <= '0; mcand <= '0; mplier <= '0;
      is_div <= 1'b0; neg_q <= 1'b0; neg_r <= 1'b0; dz <= 1'b0;
    end else begin
      if (start) begin
        busy   <= 1'b1;
        cnt    <= '0;
        acc    <= '0;
        is_div <= op[1];
        neg_q  <= a_neg ^ b_neg;
        neg_r  <= a_neg;
        dz     <= (src_b == '0);
        if (op[1]) begin
          mcand  <= {{W{1'b0}}, b_mag};
          mplier <= a_mag;
        end else begin
          mcand  <= b_neg ? -a_ext : a_ext;
          mplier <= b_neg ? -src_b : src_b;
        end
      end else if (busy) begin
        acc    <= acc_n;
        mcand  <= mcand_n;
        mplier <= mplier_n;
        cnt    <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          hi_q <= is_div ? rem : acc_n[2*W-1:W];
          lo_q <= is_div ? quo : acc_n[W-1:0];
        end
      end
      if (!busy) begin
        if (wr_hi) hi_q <= wr_data;
        if (wr_lo) lo_q <= wr_data;
      end
    end
  end

  assign hi_data    = hi_q;
  assign lo_data    = lo_q;
  assign read_stall = busy & (rd_hi | rd_lo);

  p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  p_hold_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != LAST && !start) |=> ($stable(hi_q) && $stable(lo_q)));
  p_finish_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == LAST && !start) |=> !busy);
  p_div_zero_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_div && dz && cnt == LAST && !start) |=> (lo_q == '1));
  p_direct_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_hi) |=> (hi_q == $past(wr_data)));
endmodule

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] src_a = '0, src_b = '0, wr_data = '0;
  logic        wr_hi = 1'b0, wr_lo = 1'b0, rd_hi = 1'b0, rd_lo = 1'b0;
  logic [31:0] hi_data, lo_data;
  logic        busy, read_stall;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  muldiv_unit u_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src_a(src_a), .src_b(src_b),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .hi_data(hi_data), .lo_data(lo_data), .busy(busy), .read_stall(read_stall)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] ua, ub;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'b0, a};
    ub = {32'b0, b};
    case (o)
      2'b00: return 64'(sa * sb);
      2'b01: return ua * ub;
      2'b10: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
      end
      default: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        return {32'(ua % ub), 32'(ua / ub)};
      end
    endcase
  endfunction

  task automatic launch(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op = o; src_a = a; src_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_op(input string req, input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] h0, l0;
    logic [63:0] e;
    e = model(o, a, b);
    h0 = hi_data;
    l0 = lo_data;
    launch(o, a, b);
    check("R5 busy after start", 32'(busy), 32'd1);
    repeat (31) @(negedge clk);
    check("R5 busy in last cycle", 32'(busy), 32'd1);
    check("R5 HI held while busy", hi_data, h0);
    check("R5 LO held while busy", lo_data, l0);
    @(negedge clk);
    check("R5 idle after 32 cycles", 32'(busy), 32'd0);
    check({req, " HI"}, hi_data, e[63:32]);
    check({req, " LO"}, lo_data, e[31:0]);
  endtask

  task automatic test_reset();
    check("R5 reset busy", 32'(busy), 32'd0);
    check("R6 reset HI", hi_data, 32'd0);
    check("R6 reset LO", lo_data, 32'd0);
  endtask

  task automatic test_stall();
    launch(2'b01, 32'd3, 32'd4);
    rd_hi = 1'b1;
    #1 check("R6 stall on HI read while busy", 32'(read_stall), 32'd1);
    rd_hi = 1'b0; rd_lo = 1'b1;
    #1 check("R6 stall on LO read while busy", 32'(read_stall), 32'd1);
    rd_lo = 1'b0;
    #1 check("R6 no stall without request", 32'(read_stall), 32'd0);
    repeat (32) @(negedge clk);
    rd_hi = 1'b1; rd_lo = 1'b1;
    #1 check("R6 no stall when idle", 32'(read_stall), 32'd0);
    check("R6 LO read value", lo_data, 32'd12);
    rd_hi = 1'b0; rd_lo = 1'b0;
  endtask

  task automatic test_abort();
    logic [63:0] e;
    e = model(2'b10, 32'hFFFF_FF9C, 32'd7);
    launch(2'b01, 32'hDEAD_BEEF, 32'h1234_5678);
    repeat (10) @(negedge clk);
    launch(2'b10, 32'hFFFF_FF9C, 32'd7);
    repeat (30) @(negedge clk);
    check("R8 still busy after restart", 32'(busy), 32'd1);
    check("R8 old result not written", lo_data, 32'd12);
    @(negedge clk);
    check("R8 busy at cycle 32 after restart", 32'(busy), 32'd1);
    @(negedge clk);
    check("R8 done", 32'(busy), 32'd0);
    check("R8 restarted HI", hi_data, e[63:32]);
    check("R8 restarted LO", lo_data, e[31:0]);
  endtask

  task automatic test_direct_write();
    @(negedge clk);
    wr_data = 32'hA5A5_0001; wr_hi = 1'b1;
    @(negedge clk);
    wr_hi = 1'b0; wr_data = 32'h5A5A_0002; wr_lo = 1'b1;
    @(negedge clk);
    wr_lo = 1'b0;
    check("R9 HI written when idle", hi_data, 32'hA5A5_0001);
    check("R9 LO written when idle", lo_data, 32'h5A5A_0002);
    launch(2'b01, 32'd2, 32'd5);
    wr_data = 32'h0BAD_0BAD; wr_hi = 1'b1; wr_lo = 1'b1;
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b0;
    check("R9 HI write ignored while busy", hi_data, 32'hA5A5_0001);
    check("R9 LO write ignored while busy", lo_data, 32'h5A5A_0002);
    repeat (31) @(negedge clk);
    check("R9 result after ignored write LO", lo_data, 32'd10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_op("R1 unsigned mul max", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R1 unsigned mul mixed", 2'b01, 32'h8000_0001, 32'd3);
    run_op("R2 signed mul neg*pos", 2'b00, 32'hFFFF_FFFD, 32'd7);
    run_op("R2 signed mul neg*neg", 2'b00, 32'hFFFF_FFFB, 32'hFFFF_FFFA);
    run_op("R2 signed mul min*min", 2'b00, 32'h8000_0000, 32'h8000_0000);
    run_op("R2 signed mul min*-1", 2'b00, 32'h8000_0000, 32'hFFFF_FFFF);
    run_op("R3 unsigned div", 2'b11, 32'hFFFF_FFF0, 32'd7);
    run_op("R3 unsigned div small", 2'b11, 32'd5, 32'd9);
    run_op("R4 signed div +/+", 2'b10, 32'd100, 32'd7);
    run_op("R4 signed div -/+", 2'b10, 32'hFFFF_FF9C, 32'd7);
    run_op("R4 signed div +/-", 2'b10, 32'd100, 32'hFFFF_FFF9);
    run_op("R4 signed div -/-", 2'b10, 32'hFFFF_FF9C, 32'hFFFF_FFF9);
    run_op("R7 signed div by zero", 2'b10, 32'hFFFF_FF9C, 32'd0);
    run_op("R7 unsigned div by zero", 2'b11, 32'h1234_5678, 32'd0);
    run_op("R10 signed div overflow", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
    test_stall();
    test_abort();
    test_direct_write();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule